// File: doc/BRIEF.md
# Store Queue with Load Forwarding

This block keeps the stores of an out-of-order core that have been dispatched but not yet committed, and answers every executing load with a verdict on how it may obtain its data. Stores take a slot at dispatch and receive a sequence tag for it. Their byte address and size arrive when the address is generated, and their data arrives when the data operand is ready. Slots are released one at a time, oldest first, when the core signals commit.

A load presents its byte address and size, its group tag, and the store tail tag it saw when it was dispatched. That tail tag marks which stores are older than the load. Among the older stores whose address is known and whose bytes touch the load's bytes, the youngest one decides the verdict. If no such store exists, the load reads the cache. If the load fits inside that store and the store's data is present, the data is forwarded, aligned to the load. If the load fits inside but the data is missing, the load is rejected and must be reissued. If the overlap is only partial, the load's group and everything younger must be flushed.

The allocation port uses valid/ready. A dispatch is taken only on a cycle where both are high, and ready is low while every slot is occupied. The address, data, commit and load inputs are plain strobes with no back-pressure. The response is a one-cycle strobe that the consumer must take as it appears.

Top module: `store_fwd_queue`

## Requirements
- R1: After reset the queue is empty, `alloc_ready` is 1, `tail_seq` is 0 and `rsp_valid` is 0.
- R2: A dispatch is accepted when `alloc_valid` and `alloc_ready` are both 1. The new store gets the tag `tail_seq`, and `tail_seq` then advances by one modulo 2^(index width + 1). `alloc_ready` is 0 while DEPTH stores are held, and an offered dispatch has no effect then.
- R3: `commit_valid` frees the oldest store. A commit with an empty queue is ignored. A freed store no longer takes part in any load check.
- R4: Every cycle with `ld_valid` high produces exactly one response: `rsp_valid` is 1 in the following cycle, and it is 0 in every other cycle.
- R5: Only stores older than the load count, meaning tags from the queue head up to, but not including, `ld_tail`. Stores whose address has not yet been written are also ignored.
- R6: Forward (kind code 1) is reported when the deciding store has data and the load bytes lie inside the store bytes. `rsp_data` holds the store bytes from the load address upward, with byte i in bits 8i+7..8i (little-endian), zero above the load size. Size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes.
- R7: Reject (kind code 2) is reported when the deciding store contains the load but its data has not yet been written.
- R8: Flush (kind code 3) is reported when the deciding store overlaps the load only partly, whether or not its data is present. `rsp_group` then equals the load's `ld_group`.
- R9: When several older addressed stores overlap the load, the youngest of them alone decides the verdict.
- R10: With no deciding store the verdict is cache (kind code 0). In every verdict other than forward, `rsp_data` is 0.
- R11: Age comparison works across tag wrap-around. A load whose `ld_tail` is at or behind the head, because all of its older stores have committed, reads the cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Dispatch offers a new store |
| alloc_ready | output | 1 | A free slot exists |
| tail_seq | output | SEQ_W | Tag the next accepted store receives |
| sa_valid | input | 1 | Store address write strobe |
| sa_seq | input | SEQ_W | Tag of the store receiving an address |
| sa_addr | input | ADDR_W | Store byte address |
| sa_size | input | 2 | Store size code |
| sd_valid | input | 1 | Store data write strobe |
| sd_seq | input | SEQ_W | Tag of the store receiving data |
| sd_data | input | DATA_W | Store data, byte lanes from the store address |
| commit_valid | input | 1 | Retire the oldest store |
| ld_valid | input | 1 | Load check request |
| ld_tail | input | SEQ_W | Store tail tag seen by the load at dispatch |
| ld_addr | input | ADDR_W | Load byte address |
| ld_size | input | 2 | Load size code |
| ld_group | input | GROUP_W | Group tag of the load |
| rsp_valid | output | 1 | Verdict strobe |
| rsp_kind | output | 2 | 0 cache, 1 forward, 2 reject, 3 flush |
| rsp_data | output | DATA_W | Forwarded data, zero-extended |
| rsp_group | output | GROUP_W | Group tag to flush from |

## Verification
A verdict is due exactly one clock after the edge that samples `ld_valid`, because a single register stage holds it. The driver changes inputs on falling edges, and the monitor compares at the next falling edge against the oldest queued expectation. The monitor also registers, at each rising edge, whether a load was present, so a response that comes one cycle early, comes late, or never comes is reported under R4. `alloc_ready` and `tail_seq` change at the edge that accepts a dispatch or commit, and they are read at the falling edge after it.

// File: rtl/stq_pkg.sv
package stq_pkg;
  typedef enum logic [1:0] {
    LD_CACHE  = 2'd0,
    LD_FWD    = 2'd1,
    LD_REJECT = 2'd2,
    LD_FLUSH  = 2'd3
  } ld_kind_e;
endpackage

// File: rtl/stq_entries.sv
module stq_entries #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int SEQ_W = IDX_W + 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           alloc_valid,
  output logic                           alloc_ready,
  output logic [SEQ_W-1:0]               tail_seq,
  output logic [SEQ_W-1:0]               head_seq,
  input  logic                           commit_valid,
  input  logic                           sa_valid,
  input  logic [SEQ_W-1:0]               sa_seq,
  input  logic [ADDR_W-1:0]              sa_addr,
  input  logic [1:0]                     sa_size,
  input  logic                           sd_valid,
  input  logic [SEQ_W-1:0]               sd_seq,
  input  logic [DATA_W-1:0]              sd_data,
  output logic [DEPTH-1:0]               ent_valid,
  output logic [DEPTH-1:0]               ent_addr_v,
  output logic [DEPTH-1:0]               ent_data_v,
  output logic [DEPTH-1:0][ADDR_W-1:0]   ent_addr,
  output logic [DEPTH-1:0][1:0]          ent_size,
  output logic [DEPTH-1:0][DATA_W-1:0]   ent_data
);
  logic [SEQ_W-1:0] count;
  logic alloc_fire, commit_fire, sa_live, sd_live;
  logic [SEQ_W-1:0] sa_dist, sd_dist;

  assign alloc_ready = (count != SEQ_W'(DEPTH));
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign commit_fire = commit_valid && (count != '0);
  // a write is accepted only for a tag currently held in the queue
  assign sa_dist = sa_seq - head_seq;
  assign sd_dist = sd_seq - head_seq;
  assign sa_live = sa_valid && (sa_dist < count);
  assign sd_live = sd_valid && (sd_dist < count);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_seq   <= '0;
      tail_seq   <= '0;
      count      <= '0;
      ent_valid  <= '0;
      ent_addr_v <= '0;
      ent_data_v <= '0;
    end else begin
      if (alloc_fire)  tail_seq <= tail_seq + 1'b1;
      if (commit_fire) head_seq <= head_seq + 1'b1;
      count <= count + SEQ_W'(alloc_fire) - SEQ_W'(commit_fire);
      for (int i = 0; i < DEPTH; i++) begin
        if (commit_fire && head_seq[IDX_W-1:0] == IDX_W'(i)) begin
          ent_valid[i]  <= 1'b0;
          ent_addr_v[i] <= 1'b0;
          ent_data_v[i] <= 1'b0;
        end
        if (sa_live && sa_seq[IDX_W-1:0] == IDX_W'(i)) ent_addr_v[i] <= 1'b1;
        if (sd_live && sd_seq[IDX_W-1:0] == IDX_W'(i)) ent_data_v[i] <= 1'b1;
        if (alloc_fire && tail_seq[IDX_W-1:0] == IDX_W'(i)) begin
          ent_valid[i]  <= 1'b1;
          ent_addr_v[i] <= 1'b0;
          ent_data_v[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (sa_live && sa_seq[IDX_W-1:0] == IDX_W'(i)) begin
        ent_addr[i] <= sa_addr;
        ent_size[i] <= sa_size;
      end
      if (sd_live && sd_seq[IDX_W-1:0] == IDX_W'(i)) ent_data[i] <= sd_data;
    end
  end

  // R2: occupancy never exceeds the slot count
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= SEQ_W'(DEPTH));
  // R3: the head moves by at most one slot per cycle, in order
  a_r3_head_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (head_seq == $past(head_seq)) || (head_seq == $past(head_seq) + 1'b1));
  // R3: commit on an empty queue leaves the head in place
  a_r3_empty_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && ent_valid == '0) |=> $stable(head_seq));
endmodule

// File: rtl/stq_match.sv
module stq_match #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  localparam int OFF_W = $clog2(DATA_W / 8)
) (
  input  logic [ADDR_W-1:0]             ld_addr,
  input  logic [1:0]                    ld_size,
  input  logic [DEPTH-1:0][ADDR_W-1:0]  ent_addr,
  input  logic [DEPTH-1:0][1:0]         ent_size,
  output logic [DEPTH-1:0]              ovl,
  output logic [DEPTH-1:0]              cont,
  output logic [DEPTH-1:0][OFF_W-1:0]   off
);
  localparam int EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] l_lo, l_hi;
  assign l_lo = {1'b0, ld_addr};
  assign l_hi = l_lo + (EXT_W'(1) << ld_size);

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [EXT_W-1:0] s_lo, s_hi, delta;
    assign s_lo   = {1'b0, ent_addr[g]};
    assign s_hi   = s_lo + (EXT_W'(1) << ent_size[g]);
    assign delta  = l_lo - s_lo;
    assign ovl[g]  = (l_lo < s_hi) && (s_lo < l_hi);
    assign cont[g] = (l_lo >= s_lo) && (l_hi <= s_hi);
    assign off[g]  = delta[OFF_W-1:0];
  end
endmodule

// File: rtl/stq_select.sv
module stq_select
  import stq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int SEQ_W = IDX_W + 1,
  localparam int OFF_W = $clog2(DATA_W / 8),
  localparam int NBYTE = DATA_W / 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [SEQ_W-1:0]              head_seq,
  input  logic [SEQ_W-1:0]              ld_tail,
  input  logic [1:0]                    ld_size,
  input  logic [DEPTH-1:0]              ent_valid,
  input  logic [DEPTH-1:0]              ent_addr_v,
  input  logic [DEPTH-1:0]              ent_data_v,
  input  logic [DEPTH-1:0]              ovl,
  input  logic [DEPTH-1:0]              cont,
  input  logic [DEPTH-1:0][OFF_W-1:0]   off,
  input  logic [DEPTH-1:0][DATA_W-1:0]  ent_data,
  output ld_kind_e                      kind,
  output logic [DATA_W-1:0]             fwd_data
);
  logic             found;
  logic [IDX_W-1:0] sel;
  logic [DATA_W-1:0] shifted, masked;

  // scan from the oldest store; a later hit is younger and overrides
  always_comb begin
    logic [SEQ_W-1:0] window, limit;
    logic [IDX_W-1:0] idx;
    found  = 1'b0;
    sel    = '0;
    idx    = '0;
    window = ld_tail - head_seq;
    limit  = (window > SEQ_W'(DEPTH)) ? '0 : window;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head_seq[IDX_W-1:0] + IDX_W'(k);
      if (SEQ_W'(k) < limit && ent_valid[idx] && ent_addr_v[idx] && ovl[idx]) begin
        found = 1'b1;
        sel   = idx;
      end
    end
  end

  always_comb begin
    shifted = ent_data[sel] >> {off[sel], 3'b000};
    for (int b = 0; b < NBYTE; b++)
      masked[8*b +: 8] = (b < (1 << ld_size)) ? shifted[8*b +: 8] : 8'h00;
  end

  always_comb begin
    if (!found)                 kind = LD_CACHE;
    else if (!cont[sel])        kind = LD_FLUSH;
    else if (!ent_data_v[sel])  kind = LD_REJECT;
    else                        kind = LD_FWD;
  end

  assign fwd_data = (kind == LD_FWD) ? masked : '0;

  // R8: a flush verdict needs some overlapping store
  a_r8_flush_from_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == LD_FLUSH) |-> (|ovl));
  // R6: forwarding needs a containing store holding data
  a_r6_fwd_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == LD_FWD) |-> (|(ent_data_v & cont & ovl)));
endmodule

// File: rtl/store_fwd_queue.sv
module store_fwd_queue
  import stq_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 64,
  parameter int GROUP_W = 6,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int SEQ_W  = IDX_W + 1,
  localparam int OFF_W  = $clog2(DATA_W / 8)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_valid,
  output logic               alloc_ready,
  output logic [SEQ_W-1:0]   tail_seq,
  input  logic               sa_valid,
  input  logic [SEQ_W-1:0]   sa_seq,
  input  logic [ADDR_W-1:0]  sa_addr,
  input  logic [1:0]         sa_size,
  input  logic               sd_valid,
  input  logic [SEQ_W-1:0]   sd_seq,
  input  logic [DATA_W-1:0]  sd_data,
  input  logic               commit_valid,
  input  logic               ld_valid,
  input  logic [SEQ_W-1:0]   ld_tail,
  input  logic [ADDR_W-1:0]  ld_addr,
  input  logic [1:0]         ld_size,
  input  logic [GROUP_W-1:0] ld_group,
  output logic               rsp_valid,
  output logic [1:0]         rsp_kind,
  output logic [DATA_W-1:0]  rsp_data,
  output logic [GROUP_W-1:0] rsp_group
);
  logic [SEQ_W-1:0]              head_seq;
  logic [DEPTH-1:0]              ent_valid, ent_addr_v, ent_data_v, ovl, cont;
  logic [DEPTH-1:0][ADDR_W-1:0]  ent_addr;
  logic [DEPTH-1:0][1:0]         ent_size;
  logic [DEPTH-1:0][DATA_W-1:0]  ent_data;
  logic [DEPTH-1:0][OFF_W-1:0]   off;
  ld_kind_e                      sel_kind;
  logic [DATA_W-1:0]             sel_data;

  stq_entries #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_entries (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .tail_seq(tail_seq), .head_seq(head_seq),
    .commit_valid(commit_valid),
    .sa_valid(sa_valid), .sa_seq(sa_seq), .sa_addr(sa_addr), .sa_size(sa_size),
    .sd_valid(sd_valid), .sd_seq(sd_seq), .sd_data(sd_data),
    .ent_valid(ent_valid), .ent_addr_v(ent_addr_v), .ent_data_v(ent_data_v),
    .ent_addr(ent_addr), .ent_size(ent_size), .ent_data(ent_data)
  );

  stq_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_match (
    .ld_addr(ld_addr), .ld_size(ld_size),
    .ent_addr(ent_addr), .ent_size(ent_size),
    .ovl(ovl), .cont(cont), .off(off)
  );

  stq_select #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_select (
    .clk(clk), .rst_n(rst_n),
    .head_seq(head_seq), .ld_tail(ld_tail), .ld_size(ld_size),
    .ent_valid(ent_valid), .ent_addr_v(ent_addr_v), .ent_data_v(ent_data_v),
    .ovl(ovl), .cont(cont), .off(off), .ent_data(ent_data),
    .kind(sel_kind), .fwd_data(sel_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_kind  <= LD_CACHE;
      rsp_data  <= '0;
      rsp_group <= '0;
    end else begin
      rsp_valid <= ld_valid;
      rsp_kind  <= ld_valid ? sel_kind : LD_CACHE;
      rsp_data  <= ld_valid ? sel_data : '0;
      rsp_group <= ld_valid ? ld_group : '0;
    end
  end

  // R4: a request is answered in the next cycle
  a_r4_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> rsp_valid);
  // R4: no response without a request
  a_r4_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> !rsp_valid);
  // R10: data is zero unless forwarding
  a_r10_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind != LD_FWD) |-> (rsp_data == '0));
  // R8: a flush names the load's group
  a_r8_flush_group: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == LD_FLUSH) |-> (rsp_group == $past(ld_group)));
endmodule

// File: tb/test_store_fwd_queue.sv
`timescale 1ns/1ps
module test_store_fwd_queue;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 0, alloc_ready;
  logic [3:0]  tail_seq;
  logic        sa_valid = 0; logic [3:0] sa_seq = 0; logic [15:0] sa_addr = 0; logic [1:0] sa_size = 0;
  logic        sd_valid = 0; logic [3:0] sd_seq = 0; logic [63:0] sd_data = 0;
  logic        commit_valid = 0;
  logic        ld_valid = 0; logic [3:0] ld_tail = 0; logic [15:0] ld_addr = 0;
  logic [1:0]  ld_size = 0; logic [5:0] ld_group = 0;
  logic        rsp_valid; logic [1:0] rsp_kind; logic [63:0] rsp_data; logic [5:0] rsp_group;

  store_fwd_queue i_store_fwd_queue (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .tail_seq(tail_seq),
    .sa_valid(sa_valid), .sa_seq(sa_seq), .sa_addr(sa_addr), .sa_size(sa_size),
    .sd_valid(sd_valid), .sd_seq(sd_seq), .sd_data(sd_data),
    .commit_valid(commit_valid),
    .ld_valid(ld_valid), .ld_tail(ld_tail), .ld_addr(ld_addr), .ld_size(ld_size),
    .ld_group(ld_group),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_data(rsp_data), .rsp_group(rsp_group)
  );

  always #4 clk = ~clk;

  typedef struct {
    string       req;
    logic [1:0]  kind;
    logic [63:0] data;
    logic [5:0]  grp;
  } exp_t;

  exp_t exp_q[$];
  int   vec_n = 0;
  int   miss_n = 0;
  logic ld_was = 1'b0;
  logic [3:0] sq;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vec_n++;
    if (act !== exp) begin
      miss_n++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vec_n, miss_n);
    $finish;
  endtask

  task automatic do_alloc(output logic [3:0] seq);
    seq = tail_seq;
    alloc_valid = 1'b1;
    @(negedge clk);
    alloc_valid = 1'b0;
  endtask

  task automatic do_saddr(input logic [3:0] s, input logic [15:0] a, input logic [1:0] z);
    sa_valid = 1'b1; sa_seq = s; sa_addr = a; sa_size = z;
    @(negedge clk);
    sa_valid = 1'b0;
  endtask

  task automatic do_sdata(input logic [3:0] s, input logic [63:0] d);
    sd_valid = 1'b1; sd_seq = s; sd_data = d;
    @(negedge clk);
    sd_valid = 1'b0;
  endtask

  task automatic do_commit();
    commit_valid = 1'b1;
    @(negedge clk);
    commit_valid = 1'b0;
  endtask

  task automatic do_load(input string req, input logic [3:0] t, input logic [15:0] a,
                         input logic [1:0] z, input logic [5:0] g,
                         input logic [1:0] ek, input logic [63:0] ed);
    exp_t e;
    e.req = req; e.kind = ek; e.data = ed; e.grp = g;
    exp_q.push_back(e);
    ld_valid = 1'b1; ld_tail = t; ld_addr = a; ld_size = z; ld_group = g;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  // monitor: what the design sampled at the edge decides what must show next
  always @(posedge clk) ld_was <= rst_n && ld_valid;

  always @(negedge clk) begin
    if (rst_n && (rsp_valid || ld_was)) begin
      check("R4 rsp_valid timing", {63'd0, rsp_valid}, {63'd0, ld_was});
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          check("R4 unexpected response", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check({e.req, " kind"}, {62'd0, rsp_kind}, {62'd0, e.kind});
          check({e.req, " data"}, rsp_data, e.data);
          if (e.kind == 2'd3) check("R8 flush group", {58'd0, rsp_group}, {58'd0, e.grp});
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    miss_n++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 alloc_ready", {63'd0, alloc_ready}, 64'd1);
    check("R1 tail_seq", {60'd0, tail_seq}, 64'd0);
    check("R1 rsp_valid", {63'd0, rsp_valid}, 64'd0);

    do_load("R10 empty", 4'd0, 16'h0100, 2'd3, 6'd1, 2'd0, 64'd0);

    do_alloc(sq);
    do_saddr(sq, 16'h0100, 2'd3);
    do_sdata(sq, 64'h8877665544332211);
    do_load("R6 fwd half", 4'd1, 16'h0102, 2'd1, 6'd2, 2'd1, 64'h4433);
    do_load("R6 fwd full", 4'd1, 16'h0100, 2'd3, 6'd3, 2'd1, 64'h8877665544332211);
    do_load("R6 fwd top byte", 4'd1, 16'h0107, 2'd0, 6'd4, 2'd1, 64'h88);
    do_load("R5 younger store ignored", 4'd0, 16'h0100, 2'd3, 6'd5, 2'd0, 64'd0);

    do_alloc(sq);
    do_saddr(sq, 16'h0104, 2'd2);
    do_load("R7 R9 reject", 4'd2, 16'h0104, 2'd1, 6'd6, 2'd2, 64'd0);
    do_load("R9 older only", 4'd1, 16'h0104, 2'd1, 6'd7, 2'd1, 64'h6655);
    do_load("R8 partial no data", 4'd2, 16'h0106, 2'd2, 6'h2A, 2'd3, 64'd0);
    do_load("R8 partial with data", 4'd1, 16'h0106, 2'd2, 6'h15, 2'd3, 64'd0);

    do_alloc(sq);
    do_load("R5 R10 unaddressed no overlap", 4'd3, 16'h0108, 2'd3, 6'd8, 2'd0, 64'd0);
    do_sdata(4'd1, 64'h00000000DDCCBBAA);
    do_load("R6 fwd younger", 4'd3, 16'h0104, 2'd1, 6'd9, 2'd1, 64'hBBAA);
    do_load("R6 fwd offset", 4'd3, 16'h0106, 2'd0, 6'd10, 2'd1, 64'hCC);
    do_load("R9 youngest partial", 4'd3, 16'h0100, 2'd3, 6'd11, 2'd3, 64'd0);

    for (int i = 0; i < 5; i++) do_alloc(sq);
    check("R2 full ready", {63'd0, alloc_ready}, 64'd0);
    check("R2 tail after fill", {60'd0, tail_seq}, 64'd8);
    do_alloc(sq);
    check("R2 blocked alloc", {60'd0, tail_seq}, 64'd8);

    do_commit();
    check("R3 ready after commit", {63'd0, alloc_ready}, 64'd1);
    do_load("R3 R11 committed store gone", 4'd1, 16'h0100, 2'd3, 6'd12, 2'd0, 64'd0);
    do_load("R3 remaining store", 4'd2, 16'h0104, 2'd1, 6'd13, 2'd1, 64'hBBAA);

    for (int i = 0; i < 7; i++) do_commit();
    do_commit();
    check("R3 empty commit ignored", {63'd0, alloc_ready}, 64'd1);
    for (int i = 0; i < 7; i++) begin
      do_alloc(sq);
      do_commit();
    end
    check("R2 tail before wrap", {60'd0, tail_seq}, 64'd15);

    do_alloc(sq);
    do_saddr(sq, 16'h0300, 2'd3);
    do_sdata(sq, 64'h0123456789ABCDEF);
    do_alloc(sq);
    check("R11 tag wrapped", {60'd0, sq}, 64'd0);
    do_saddr(sq, 16'h0300, 2'd3);
    do_load("R11 fwd across wrap", 4'd0, 16'h0300, 2'd3, 6'd14, 2'd1, 64'h0123456789ABCDEF);
    do_load("R11 fwd slice across wrap", 4'd0, 16'h0302, 2'd1, 6'd15, 2'd1, 64'h89AB);
    do_load("R11 R9 reject across wrap", 4'd1, 16'h0300, 2'd0, 6'd16, 2'd2, 64'd0);

    for (int i = 0; i < 6; i++) do_alloc(sq);
    check("R2 full after wrap", {63'd0, alloc_ready}, 64'd0);
    check("R2 tail after wrap", {60'd0, tail_seq}, 64'd7);

    repeat (3) @(negedge clk);
    check("R4 all responses seen", 64'(exp_q.size()), 64'd0);
    finish_run();
  end
endmodule